// File: doc/BRIEF.md
# SCSI Initiator Bus Register Interface

This block sits between a byte-wide host register port and the control and data lines of a parallel SCSI bus. Eight byte registers are selected by a three-bit address. Host writes load an output data latch, an initiator command register, a mode register, a target command register and a select enable register. The control and data lines are driven straight from these registers. Host reads return the stored registers or status bytes built from the sampled bus lines.

The block also records which target a selection is aimed at, and it keeps an interrupt flag and an end-of-DMA flag. Two write-only locations start a DMA send or a DMA initiator-receive transfer; the block only reports the DMA state. An external engine moves the bytes and ends the transfer with a one-cycle `eop_i` pulse.

Reads return data combinationally in the cycle `rd_i` is high. A read's side effects (setting or clearing the interrupt) take effect at the clock edge that ends that read. The byte returned is the value from before that edge.

Top module: `scsi_host_regs`

## Requirements
- R1: After reset, every register and flag is zero, the DMA state is idle (code 0), all bus outputs are low, and reading address 5 with all bus inputs low returns 0x08.
- R2: Reading address 7 returns 0xFF. Writing address 6 changes no register and no DMA state. Writing address 4 loads `sel_enable_o`.
- R3: Reading address 0 returns the output latch when command bit 0 is set, and `bus_data_i` otherwise. Reading address 6 always returns `bus_data_i`.
- R4: Initiator command bits 0..4 drive `bus_data_oe_o`, `bus_atn_o`, `bus_sel_o`, `bus_bsy_o` and `bus_ack_o`. `bus_data_o` carries the output latch. The command register holds bits 6..0, and bit 7 reads 0.
- R5: A command write that sets bits 3 and 2 (BSY, SEL), when the old value had bit 2 set and bit 3 clear, loads `target_id_o` with the index of the highest set bit in latch bits 6..0. `target_vld_o` is set if any of those bits is set; if none is set, both outputs are 0. Any other command write leaves both outputs unchanged.
- R6: A mode write that changes mode bit 0 (arbitrate) from 0 to 1 clears command bit 5 and sets command bit 6. `bus_arb_o` follows mode bit 0.
- R7: Target command bits 3..0 drive `bus_req_o`, `bus_msg_o`, `bus_cd_o` and `bus_io_o` (bit 3 down to bit 0). Host writes to bits 7..4 are ignored. Bit 7 (last byte sent) reads back from its own flag.
- R8: Writing address 5 sets the DMA state to send (code 1). Writing address 7 sets it to initiator-receive (code 2).
- R9: A mode write with bit 1 (DMA mode) clear clears the last-byte-sent flag and the end-of-DMA flag and returns the DMA state to idle.
- R10: The address 4 byte reports the live bus lines: bit 7 RST, bit 6 BSY, bit 5 REQ, bit 4 MSG, bit 3 C/D, bit 2 I/O, bit 1 SEL, bit 0 zero.
- R11: The address 5 byte reports the following, with all other bits zero:
  - bit 0: bus ACK
  - bit 2: BSY is absent while mode bit 2 is set
  - bit 3: bus {MSG,C/D,I/O} equals target command bits 2..0
  - bit 4: the interrupt flag
  - bit 6: REQ is asserted while mode bit 1 is set
  - bit 7: the end-of-DMA flag
- R12: A read of address 5 sets the interrupt flag (`irq_o`) when REQ is asserted, mode bit 1 is set and the bus phase differs from target command bits 2..0. A read of address 4 never does this. A read of address 7 clears the flag.
- R13: An `eop_i` pulse has effect only while mode bit 1 is set. It then sets the end-of-DMA flag, and it also sets last-byte-sent when the DMA state is send. If mode bit 3 is set, it also sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| bus_data_i | input | 8 | Sampled bus data |
| bus_rst_i | input | 1 | Sampled RST |
| bus_bsy_i | input | 1 | Sampled BSY |
| bus_sel_i | input | 1 | Sampled SEL |
| bus_req_i | input | 1 | Sampled REQ |
| bus_ack_i | input | 1 | Sampled ACK |
| bus_msg_i | input | 1 | Sampled MSG |
| bus_cd_i | input | 1 | Sampled C/D |
| bus_io_i | input | 1 | Sampled I/O |
| eop_i | input | 1 | End-of-transfer pulse from the DMA engine |
| bus_data_o | output | 8 | Driven bus data |
| bus_data_oe_o | output | 1 | Data bus drive enable |
| bus_atn_o | output | 1 | Driven ATN |
| bus_sel_o | output | 1 | Driven SEL |
| bus_bsy_o | output | 1 | Driven BSY |
| bus_ack_o | output | 1 | Driven ACK |
| bus_io_o | output | 1 | Driven I/O |
| bus_cd_o | output | 1 | Driven C/D |
| bus_msg_o | output | 1 | Driven MSG |
| bus_req_o | output | 1 | Driven REQ |
| bus_arb_o | output | 1 | Arbitration request |
| sel_enable_o | output | 8 | Select enable register |
| target_id_o | output | 3 | Captured selection target ID |
| target_vld_o | output | 1 | Target ID is valid |
| dma_state_o | output | 2 | 0 idle, 1 send, 2 initiator-receive |
| irq_o | output | 1 | Interrupt flag |

## Verification
On every cycle, assertions check the following:
- each read of address 7 clears the interrupt;
- each mismatching status read raises it;
- a DMA-off mode write clears the DMA flags and state;
- the last-byte-sent and end-of-DMA flags never exist without DMA mode;
- an arbitrate rising edge updates the arbitration bits.

Only the bench scenarios can show the full byte values of the status compositions, the target ID chosen from particular latch patterns, and that a status read of address 4 or an `eop_i` with DMA mode off leaves the flags alone.

// File: rtl/scsi_hr_pkg.sv
package scsi_hr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_DATA   = 3'd0;
  localparam logic [AW-1:0] A_ICMD   = 3'd1;
  localparam logic [AW-1:0] A_MODE   = 3'd2;
  localparam logic [AW-1:0] A_TCMD   = 3'd3;
  localparam logic [AW-1:0] A_SELBUS = 3'd4;
  localparam logic [AW-1:0] A_DSEND  = 3'd5;
  localparam logic [AW-1:0] A_INDATA = 3'd6;
  localparam logic [AW-1:0] A_DRECV  = 3'd7;

  // initiator command bits
  localparam int unsigned IC_DOE  = 0;
  localparam int unsigned IC_ATN  = 1;
  localparam int unsigned IC_SEL  = 2;
  localparam int unsigned IC_BSY  = 3;
  localparam int unsigned IC_ACK  = 4;
  localparam int unsigned IC_LOST = 5;
  localparam int unsigned IC_AIP  = 6;

  // mode bits
  localparam int unsigned MD_ARB  = 0;
  localparam int unsigned MD_DMA  = 1;
  localparam int unsigned MD_MBSY = 2;
  localparam int unsigned MD_EOPI = 3;

  typedef enum logic [1:0] {
    DMA_IDLE  = 2'd0,
    DMA_SEND  = 2'd1,
    DMA_IRECV = 2'd2
  } dma_state_e;
endpackage

// File: rtl/scsi_hr_msb_enc.sv
module scsi_hr_msb_enc #(
  parameter int unsigned N = 7,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/scsi_hr_ctrl.sv
module scsi_hr_ctrl
  import scsi_hr_pkg::*;
#(
  parameter int unsigned ID_N = DW - 1,
  localparam int unsigned ID_W = $clog2(ID_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eop_i,
  input  logic          mismatch_i,
  output logic [DW-1:0] odata_o,
  output logic [6:0]    icmd_o,
  output logic [DW-1:0] mode_o,
  output logic [3:0]    tcmd_o,
  output logic          lbs_o,
  output logic [DW-1:0] sel_en_o,
  output dma_state_e    dma_state_o,
  output logic          int_o,
  output logic          end_o,
  output logic [ID_W-1:0] tid_o,
  output logic          tid_vld_o
);
  logic          wr_data, wr_icmd, wr_mode, wr_tcmd, wr_sel, wr_send, wr_recv;
  logic          rd_clr, rd_bas, dma_off, arb_rise, sel_to_bsy, eop_act;
  logic [ID_W-1:0] enc_idx;
  logic          enc_any;

  assign wr_data  = wr_i && addr_i == A_DATA;
  assign wr_icmd  = wr_i && addr_i == A_ICMD;
  assign wr_mode  = wr_i && addr_i == A_MODE;
  assign wr_tcmd  = wr_i && addr_i == A_TCMD;
  assign wr_sel   = wr_i && addr_i == A_SELBUS;
  assign wr_send  = wr_i && addr_i == A_DSEND;
  assign wr_recv  = wr_i && addr_i == A_DRECV;
  assign rd_clr   = rd_i && addr_i == A_DRECV;
  assign rd_bas   = rd_i && addr_i == A_DSEND;
  assign dma_off  = wr_mode && !wdata_i[MD_DMA];
  assign arb_rise = wr_mode && wdata_i[MD_ARB] && !mode_o[MD_ARB];
  assign sel_to_bsy = wr_icmd && wdata_i[IC_BSY] && wdata_i[IC_SEL] &&
                      icmd_o[IC_SEL] && !icmd_o[IC_BSY];
  assign eop_act  = eop_i && mode_o[MD_DMA];

  scsi_hr_msb_enc #(.N(ID_N)) u_enc (
    .vec_i (odata_o[ID_N-1:0]),
    .idx_o (enc_idx),
    .any_o (enc_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odata_o  <= '0;
      sel_en_o <= '0;
      tcmd_o   <= '0;
    end else begin
      if (wr_data) odata_o  <= wdata_i;
      if (wr_sel)  sel_en_o <= wdata_i;
      if (wr_tcmd) tcmd_o   <= wdata_i[3:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icmd_o <= '0;
    end else if (wr_icmd) begin
      icmd_o <= wdata_i[6:0];
    end else if (arb_rise) begin
      icmd_o[IC_LOST] <= 1'b0;
      icmd_o[IC_AIP]  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tid_o     <= '0;
      tid_vld_o <= 1'b0;
    end else if (sel_to_bsy) begin
      tid_o     <= enc_idx;
      tid_vld_o <= enc_any;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= '0;
      dma_state_o <= DMA_IDLE;
      lbs_o       <= 1'b0;
      end_o       <= 1'b0;
    end else begin
      if (wr_mode) mode_o <= wdata_i;
      if (dma_off) begin
        dma_state_o <= DMA_IDLE;
        lbs_o       <= 1'b0;
        end_o       <= 1'b0;
      end else begin
        if (wr_send) dma_state_o <= DMA_SEND;
        if (wr_recv) dma_state_o <= DMA_IRECV;
        if (eop_act) begin
          end_o <= 1'b1;
          if (dma_state_o == DMA_SEND) lbs_o <= 1'b1;
        end
      end
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_o <= 1'b0;
    else if ((rd_bas && mismatch_i) || (eop_act && mode_o[MD_EOPI])) int_o <= 1'b1;
    else if (rd_clr) int_o <= 1'b0;
  end

  assert_int_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr && !(eop_i && mode_o[MD_DMA] && mode_o[MD_EOPI]) |=> !int_o);
  assert_dma_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_MODE && !wdata_i[MD_DMA] |=> dma_state_o == DMA_IDLE && !lbs_o && !end_o);
  assert_arb_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_MODE && wdata_i[MD_ARB] && !mode_o[MD_ARB] |=> icmd_o[IC_AIP] && !icmd_o[IC_LOST]);
  assert_flags_need_dma_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbs_o || end_o) |-> mode_o[MD_DMA]);
  assert_dma_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_DSEND |=> dma_state_o == DMA_SEND);
  assert_tid_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_ICMD) |=> $stable(tid_o) && $stable(tid_vld_o));
endmodule

// File: rtl/scsi_hr_status.sv
module scsi_hr_status
  import scsi_hr_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] odata_i,
  input  logic [6:0]    icmd_i,
  input  logic [DW-1:0] mode_i,
  input  logic [3:0]    tcmd_i,
  input  logic          lbs_i,
  input  logic          int_i,
  input  logic          end_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_rst_i,
  input  logic          bus_bsy_i,
  input  logic          bus_sel_i,
  input  logic          bus_req_i,
  input  logic          bus_ack_i,
  input  logic          bus_msg_i,
  input  logic          bus_cd_i,
  input  logic          bus_io_i,
  output logic [DW-1:0] rdata_o,
  output logic          mismatch_o
);
  logic [2:0]    phase;
  logic          phase_ok, drq;
  logic [DW-1:0] bus_byte, bas_byte;

  assign phase      = {bus_msg_i, bus_cd_i, bus_io_i};
  assign phase_ok   = phase == tcmd_i[2:0];
  assign drq        = bus_req_i && mode_i[MD_DMA];
  assign mismatch_o = drq && !phase_ok;

  assign bus_byte = {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i,
                     bus_cd_i, bus_io_i, bus_sel_i, 1'b0};
  assign bas_byte = {end_i, drq, 1'b0, int_i, phase_ok,
                     !bus_bsy_i && mode_i[MD_MBSY], 1'b0, bus_ack_i};

  always_comb begin
    unique case (addr_i)
      A_DATA:   rdata_o = icmd_i[IC_DOE] ? odata_i : bus_data_i;
      A_ICMD:   rdata_o = {1'b0, icmd_i};
      A_MODE:   rdata_o = mode_i;
      A_TCMD:   rdata_o = {lbs_i, 3'b000, tcmd_i};
      A_SELBUS: rdata_o = bus_byte;
      A_DSEND:  rdata_o = bas_byte;
      A_INDATA: rdata_o = bus_data_i;
      default:  rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_hr_pkg::*;
#(
  parameter int unsigned ID_N = DW - 1,
  localparam int unsigned ID_W = $clog2(ID_N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [DW-1:0]   bus_data_i,
  input  logic            bus_rst_i,
  input  logic            bus_bsy_i,
  input  logic            bus_sel_i,
  input  logic            bus_req_i,
  input  logic            bus_ack_i,
  input  logic            bus_msg_i,
  input  logic            bus_cd_i,
  input  logic            bus_io_i,
  input  logic            eop_i,
  output logic [DW-1:0]   bus_data_o,
  output logic            bus_data_oe_o,
  output logic            bus_atn_o,
  output logic            bus_sel_o,
  output logic            bus_bsy_o,
  output logic            bus_ack_o,
  output logic            bus_io_o,
  output logic            bus_cd_o,
  output logic            bus_msg_o,
  output logic            bus_req_o,
  output logic            bus_arb_o,
  output logic [DW-1:0]   sel_enable_o,
  output logic [ID_W-1:0] target_id_o,
  output logic            target_vld_o,
  output logic [1:0]      dma_state_o,
  output logic            irq_o
);
  logic [DW-1:0] odata, mode;
  logic [6:0]    icmd;
  logic [3:0]    tcmd;
  logic          lbs, int_flag, end_flag, mismatch;
  dma_state_e    dma_state;

  scsi_hr_ctrl #(.ID_N(ID_N)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .eop_i       (eop_i),
    .mismatch_i  (mismatch),
    .odata_o     (odata),
    .icmd_o      (icmd),
    .mode_o      (mode),
    .tcmd_o      (tcmd),
    .lbs_o       (lbs),
    .sel_en_o    (sel_enable_o),
    .dma_state_o (dma_state),
    .int_o       (int_flag),
    .end_o       (end_flag),
    .tid_o       (target_id_o),
    .tid_vld_o   (target_vld_o)
  );

  scsi_hr_status u_stat (
    .addr_i     (addr_i),
    .odata_i    (odata),
    .icmd_i     (icmd),
    .mode_i     (mode),
    .tcmd_i     (tcmd),
    .lbs_i      (lbs),
    .int_i      (int_flag),
    .end_i      (end_flag),
    .bus_data_i (bus_data_i),
    .bus_rst_i  (bus_rst_i),
    .bus_bsy_i  (bus_bsy_i),
    .bus_sel_i  (bus_sel_i),
    .bus_req_i  (bus_req_i),
    .bus_ack_i  (bus_ack_i),
    .bus_msg_i  (bus_msg_i),
    .bus_cd_i   (bus_cd_i),
    .bus_io_i   (bus_io_i),
    .rdata_o    (rdata_o),
    .mismatch_o (mismatch)
  );

  assign bus_data_o    = odata;
  assign bus_data_oe_o = icmd[IC_DOE];
  assign bus_atn_o     = icmd[IC_ATN];
  assign bus_sel_o     = icmd[IC_SEL];
  assign bus_bsy_o     = icmd[IC_BSY];
  assign bus_ack_o     = icmd[IC_ACK];
  assign bus_io_o      = tcmd[0];
  assign bus_cd_o      = tcmd[1];
  assign bus_msg_o     = tcmd[2];
  assign bus_req_o     = tcmd[3];
  assign bus_arb_o     = mode[MD_ARB];
  assign dma_state_o   = dma_state;
  assign irq_o         = int_flag;

  assert_mismatch_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_DSEND && bus_req_i && mode[MD_DMA] &&
    {bus_msg_i, bus_cd_i, bus_io_i} != tcmd[2:0] |=> irq_o);
  assert_undef_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_DRECV |-> rdata_o == 8'hFF);
  assert_drq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_DSEND && rdata_o[6] |-> bus_req_i);
endmodule

// File: tb/sim_scsi_host_regs.sv
module sim_scsi_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, eop = 1'b0;
  logic [7:0] wdata = '0, rdata, bus_data = '0, bdo, sel_en;
  logic       b_rst = 0, b_bsy = 0, b_sel = 0, b_req = 0, b_ack = 0, b_msg = 0, b_cd = 0, b_io = 0;
  logic       oe, atn, sel, bsy, ack, io, cd, msg, req, arb, tvld, irq;
  logic [2:0] tid;
  logic [1:0] dst;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  scsi_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .bus_data_i(bus_data),
    .bus_rst_i(b_rst), .bus_bsy_i(b_bsy), .bus_sel_i(b_sel), .bus_req_i(b_req),
    .bus_ack_i(b_ack), .bus_msg_i(b_msg), .bus_cd_i(b_cd), .bus_io_i(b_io),
    .eop_i(eop), .bus_data_o(bdo), .bus_data_oe_o(oe), .bus_atn_o(atn),
    .bus_sel_o(sel), .bus_bsy_o(bsy), .bus_ack_o(ack), .bus_io_o(io),
    .bus_cd_o(cd), .bus_msg_o(msg), .bus_req_o(req), .bus_arb_o(arb),
    .sel_enable_o(sel_en), .target_id_o(tid), .target_vld_o(tvld),
    .dma_state_o(dst), .irq_o(irq)
  );

  // monitor: mid-cycle sample of read data against the scoreboard
  always @(negedge clk) begin
    if (rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: got %02h", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s addr=%0d got=%02h exp=%02h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1; addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic pulse_eop();
    @(posedge clk); #1; eop = 1'b1;
    @(posedge clk); #1; eop = 1'b0;
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", t, got, e);
    end
  endtask

  task automatic set_bus(input logic r, input logic b, input logic s, input logic q,
                         input logic k, input logic m, input logic c, input logic i);
    b_rst = r; b_bsy = b; b_sel = s; b_req = q; b_ack = k; b_msg = m; b_cd = c; b_io = i;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({irq, dst, oe, atn, sel, bsy, ack}, 8'h00, "R1 flags/lines");
    chk({io, cd, msg, req, arb, tvld, tid}, 8'h00, "R1 target lines");
    rd_reg(3'd1, 8'h00, "R1 icmd");
    rd_reg(3'd2, 8'h00, "R1 mode");
    rd_reg(3'd3, 8'h00, "R1 tcmd");
    rd_reg(3'd5, 8'h08, "R1 bas");
    rd_reg(3'd7, 8'hFF, "R2 undef read");

    // R3 data path
    bus_data = 8'h5A;
    rd_reg(3'd0, 8'h5A, "R3 bus data");
    wr_reg(3'd0, 8'hA5);
    rd_reg(3'd0, 8'h5A, "R3 latch hidden");
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd0, 8'hA5, "R3 latch shown");
    @(negedge clk);
    chk({7'd0, oe}, 8'h01, "R4 oe");
    chk(bdo, 8'hA5, "R4 data out");
    rd_reg(3'd6, 8'h5A, "R3 input data");

    // R4 command lines
    wr_reg(3'd1, 8'h1E);
    @(negedge clk);
    chk({3'd0, atn, sel, bsy, ack, oe}, 8'h1E, "R4 lines");
    rd_reg(3'd1, 8'h1E, "R4 icmd read");
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, 8'h7F, "R4 bit7 zero");
    @(negedge clk);
    chk({7'd0, tvld}, 8'h00, "R5 no capture old bsy");

    // R5 target ID
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd0, 8'h28);
    wr_reg(3'd1, 8'h0C);
    @(negedge clk);
    chk({7'd0, tvld}, 8'h00, "R5 no capture old sel clear");
    wr_reg(3'd1, 8'h04);
    wr_reg(3'd1, 8'h0C);
    @(negedge clk);
    chk({4'd0, tvld, tid}, 8'h0D, "R5 id 5");
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd0, 8'h81);
    wr_reg(3'd1, 8'h04);
    wr_reg(3'd1, 8'h0C);
    @(negedge clk);
    chk({4'd0, tvld, tid}, 8'h08, "R5 id 0 ignores bit7");
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd0, 8'h80);
    wr_reg(3'd1, 8'h04);
    wr_reg(3'd1, 8'h0C);
    @(negedge clk);
    chk({4'd0, tvld, tid}, 8'h00, "R5 no bits set");
    wr_reg(3'd1, 8'h00);

    // R6 arbitration
    wr_reg(3'd1, 8'h20);
    wr_reg(3'd2, 8'h01);
    rd_reg(3'd1, 8'h40, "R6 rising edge");
    @(negedge clk);
    chk({7'd0, arb}, 8'h01, "R6 arb out");
    wr_reg(3'd1, 8'h20);
    wr_reg(3'd2, 8'h01);
    rd_reg(3'd1, 8'h20, "R6 no edge");
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd1, 8'h00);
    @(negedge clk);
    chk({7'd0, arb}, 8'h00, "R6 arb off");

    // R7 target command
    wr_reg(3'd3, 8'hFF);
    rd_reg(3'd3, 8'h0F, "R7 upper ignored");
    @(negedge clk);
    chk({4'd0, req, msg, cd, io}, 8'h0F, "R7 lines");
    wr_reg(3'd3, 8'h00);

    // R8 / R2 DMA starts and ignored write
    wr_reg(3'd5, 8'h00);
    @(negedge clk);
    chk({6'd0, dst}, 8'h01, "R8 send");
    wr_reg(3'd7, 8'h00);
    @(negedge clk);
    chk({6'd0, dst}, 8'h02, "R8 irecv");
    wr_reg(3'd6, 8'hFF);
    @(negedge clk);
    chk({6'd0, dst}, 8'h02, "R2 addr6 write dma");
    rd_reg(3'd1, 8'h00, "R2 addr6 write icmd");
    rd_reg(3'd2, 8'h00, "R2 addr6 write mode");
    rd_reg(3'd3, 8'h00, "R2 addr6 write tcmd");
    wr_reg(3'd4, 8'h3C);
    @(negedge clk);
    chk(sel_en, 8'h3C, "R2 select enable");
    wr_reg(3'd2, 8'h00);
    @(negedge clk);
    chk({6'd0, dst}, 8'h00, "R9 idle");

    // R13 / R9 send end
    wr_reg(3'd2, 8'h0A);
    wr_reg(3'd5, 8'h00);
    pulse_eop();
    @(negedge clk);
    chk({7'd0, irq}, 8'h01, "R13 eop irq");
    rd_reg(3'd3, 8'h80, "R13 last byte sent");
    rd_reg(3'd5, 8'h98, "R11 end+int");
    rd_reg(3'd7, 8'hFF, "R12 clear read");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R12 cleared");
    wr_reg(3'd2, 8'h02);
    rd_reg(3'd3, 8'h80, "R9 kept with dma on");
    wr_reg(3'd2, 8'h00);
    rd_reg(3'd3, 8'h00, "R9 lbs cleared");
    rd_reg(3'd5, 8'h08, "R9 end cleared");
    @(negedge clk);
    chk({6'd0, dst}, 8'h00, "R9 dma idle");

    // R13 receive end, no interrupt enable
    wr_reg(3'd2, 8'h02);
    wr_reg(3'd7, 8'h00);
    pulse_eop();
    rd_reg(3'd3, 8'h00, "R13 no lbs on receive");
    rd_reg(3'd5, 8'h88, "R13 end flag");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R13 no irq without enable");
    wr_reg(3'd2, 8'h00);
    pulse_eop();
    rd_reg(3'd5, 8'h08, "R13 eop ignored dma off");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R13 irq ignored dma off");

    // R10 bus status
    set_bus(1, 1, 1, 1, 0, 0, 1, 0);
    rd_reg(3'd4, 8'hEA, "R10 pattern a");
    set_bus(0, 0, 0, 0, 0, 1, 0, 1);
    rd_reg(3'd4, 8'h14, "R10 pattern b");

    // R11 / R12 phase mismatch
    set_bus(0, 0, 0, 1, 1, 0, 1, 0);
    wr_reg(3'd2, 8'h06);
    rd_reg(3'd4, 8'h28, "R10 pattern c");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R12 addr4 no irq");
    rd_reg(3'd5, 8'h45, "R11 ack busyerr drq");
    @(negedge clk);
    chk({7'd0, irq}, 8'h01, "R12 mismatch irq");
    rd_reg(3'd5, 8'h55, "R11 int bit");
    rd_reg(3'd7, 8'hFF, "R12 clear");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R12 cleared again");
    b_bsy = 1'b1;
    wr_reg(3'd3, 8'h02);
    rd_reg(3'd5, 8'h49, "R11 phase match");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R12 match no irq");
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd3, 8'h00);
    rd_reg(3'd5, 8'h01, "R11 dma off");
    @(negedge clk);
    chk({7'd0, irq}, 8'h00, "R12 dma off no irq");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule